// File: doc/BRIEF.md
# Privileged Trap Entry Unit

This block performs the architectural state update when a core takes a trap. The core presents a one-cycle trap request with four pieces of data: a cause word, the program counter of the trapping instruction, an optional faulting address, and the privilege level it was running at. The block decides whether the trap is handled at supervisor or at machine level. It then saves the trap context into the registers of the chosen level, stacks the interrupt-enable bit, and reports the handler address and the new privilege level one clock later.

The block holds the machine and supervisor trap vectors, the exception and interrupt delegation masks, and the status bits that trap entry touches. It also holds the saved PC, cause and faulting address for each level. The vectors, the delegation masks and the status bits can be written through a simple select/data write port. All held state is visible on output ports so that the surrounding core can read it.

Top module: `trap_entry_unit`

## Requirements
- R1: Bit 31 of `trap_cause_i` set marks an interrupt. The cause number is the cause with bit 31 cleared. Interrupts look up the interrupt delegation mask and exceptions look up the exception delegation mask, each at bit index = cause number.
- R2: A trap goes to supervisor level (`next_priv_o` = 1) only when three conditions hold: `cur_priv_i` is 0 (user) or 1 (supervisor), the cause number is below 32, and the selected delegation bit is 1. Any other trap goes to machine level (`next_priv_o` = 3).
- R3: On a supervisor trap, the unit stores the PC in `sepc_o`, the full cause in `scause_o` and the faulting address in `sbad_o` (always, whether marked valid or not). It also copies the old SIE (status bit 1) into SPIE (bit 5), writes bit 0 of the old privilege into SPP (bit 8), and clears SIE.
- R4: On a machine trap, the unit stores the PC in `mepc_o` and the full cause in `mcause_o`. It also copies the old MIE (status bit 3) into MPIE (bit 7), writes the old privilege into MPP (bits 12:11), and clears MIE.
- R5: On a machine trap, `mbad_o` takes the faulting address only when `trap_bad_valid_i` is 1. Otherwise it keeps its value.
- R6: The handler address is the selected level's vector with bit 0 cleared. When bit 0 of that vector is 1 and the trap is an interrupt, 4 × cause number is added, modulo 2^32.
- R7: A write with `csr_sel_i` = 0 (machine vector) or 1 (supervisor vector) stores the data with bit 1 forced to 0. Select 2 writes the exception delegation mask and select 3 writes the interrupt delegation mask, both unmodified.
- R8: A write with `csr_sel_i` = 4 loads SIE, MIE, SPIE, MPIE, SPP and MPP from data bits 1, 3, 5, 7, 8 and 12:11. `status_o` shows these fields at the same positions and 0 elsewhere.
- R9: Trap results appear on the first rising edge after the request, and `redirect_o` is high for exactly that one cycle. After reset, all registers are 0, `next_pc_o` is 0 and `next_priv_o` is 3.
- R10: A CSR write presented in the same cycle as a trap request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid_i | input | 1 | One-cycle trap request |
| trap_cause_i | input | 32 | Cause word, bit 31 = interrupt |
| trap_epc_i | input | 32 | PC of the trapping instruction |
| trap_bad_i | input | 32 | Faulting address |
| trap_bad_valid_i | input | 1 | Faulting address is meaningful |
| cur_priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 3 | CSR select (0 mvec, 1 svec, 2 exc deleg, 3 irq deleg, 4 status) |
| csr_wdata_i | input | 32 | CSR write data |
| redirect_o | output | 1 | Handler address valid this cycle |
| next_pc_o | output | 32 | Handler address |
| next_priv_o | output | 2 | Privilege after the trap |
| status_o | output | 32 | Status bits |
| mvec_o | output | 32 | Machine trap vector |
| svec_o | output | 32 | Supervisor trap vector |
| medeleg_o | output | 32 | Exception delegation mask |
| mideleg_o | output | 32 | Interrupt delegation mask |
| mepc_o | output | 32 | Machine saved PC |
| mcause_o | output | 32 | Machine saved cause |
| mbad_o | output | 32 | Machine saved faulting address |
| sepc_o | output | 32 | Supervisor saved PC |
| scause_o | output | 32 | Supervisor saved cause |
| sbad_o | output | 32 | Supervisor saved faulting address |

## Verification
Every result of a trap request or CSR write is due exactly one rising edge after the request, because only one register stage lies between the inputs and every output. The bench drives each request on a falling edge and samples all outputs on the next falling edge. It then samples `redirect_o` once more one cycle later to confirm that the pulse has ended. The sweep covers every privilege level, both trap kinds, every cause number from 0 to 31 and out-of-range cause numbers, with a changing status pattern before each trap.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef logic [1:0] priv_t;
    localparam priv_t PRIV_U = 2'd0;
    localparam priv_t PRIV_S = 2'd1;
    localparam priv_t PRIV_M = 2'd3;

    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;

    typedef enum logic [2:0] {
        SEL_MVEC    = 3'd0,
        SEL_SVEC    = 3'd1,
        SEL_EXC_DLG = 3'd2,
        SEL_IRQ_DLG = 3'd3,
        SEL_STATUS  = 3'd4
    } csr_sel_e;

    typedef struct packed {
        logic  sie;
        logic  mie;
        logic  spie;
        logic  mpie;
        logic  spp;
        priv_t mpp;
    } stat_t;
endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause_i,
    input  priv_t           priv_i,
    input  logic [XLEN-1:0] exc_dlg_i,
    input  logic [XLEN-1:0] irq_dlg_i,
    output logic            is_irq_o,
    output logic [XLEN-1:0] num_o,
    output logic            to_s_o
);
    localparam int IDX_W = $clog2(XLEN);

    logic [XLEN-1:0] dlg;
    logic            in_range;
    logic            low_priv;

    always_comb begin
        is_irq_o = cause_i[XLEN-1];
        num_o    = {1'b0, cause_i[XLEN-2:0]};
        dlg      = is_irq_o ? irq_dlg_i : exc_dlg_i;
        in_range = (num_o < XLEN'(XLEN));
        low_priv = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        to_s_o   = low_priv && in_range && dlg[num_o[IDX_W-1:0]];
    end
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] vec_i,
    input  logic            is_irq_i,
    input  logic [XLEN-1:0] num_i,
    output logic [XLEN-1:0] target_o
);
    logic [XLEN-1:0] base;

    always_comb begin
        base = {vec_i[XLEN-1:1], 1'b0};
        if (vec_i[0] && is_irq_i) begin
            target_o = base + (num_i << 2);
        end else begin
            target_o = base;
        end
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid_i,
    input  logic [XLEN-1:0] trap_cause_i,
    input  logic [XLEN-1:0] trap_epc_i,
    input  logic [XLEN-1:0] trap_bad_i,
    input  logic            trap_bad_valid_i,
    input  logic [1:0]      cur_priv_i,
    input  logic            csr_we_i,
    input  logic [2:0]      csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic [1:0]      next_priv_o,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] mvec_o,
    output logic [XLEN-1:0] svec_o,
    output logic [XLEN-1:0] medeleg_o,
    output logic [XLEN-1:0] mideleg_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mbad_o,
    output logic [XLEN-1:0] sepc_o,
    output logic [XLEN-1:0] scause_o,
    output logic [XLEN-1:0] sbad_o
);
    typedef struct packed {
        stat_t           st;
        logic [XLEN-1:0] mvec;
        logic [XLEN-1:0] svec;
        logic [XLEN-1:0] exc_dlg;
        logic [XLEN-1:0] irq_dlg;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mbad;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sbad;
        logic [XLEN-1:0] pc;
        priv_t           priv;
        logic            redirect;
    } regs_t;

    localparam logic [XLEN-1:0] VEC_WMASK = ~(XLEN'(2));

    regs_t r_d, r_q;

    logic            is_irq;
    logic [XLEN-1:0] cause_num;
    logic            to_s;
    logic [XLEN-1:0] m_target;
    logic [XLEN-1:0] s_target;

    trap_route #(.XLEN(XLEN)) route_i (
        .cause_i   (trap_cause_i),
        .priv_i    (cur_priv_i),
        .exc_dlg_i (r_q.exc_dlg),
        .irq_dlg_i (r_q.irq_dlg),
        .is_irq_o  (is_irq),
        .num_o     (cause_num),
        .to_s_o    (to_s)
    );

    trap_vector_calc #(.XLEN(XLEN)) mvec_calc_i (
        .vec_i    (r_q.mvec),
        .is_irq_i (is_irq),
        .num_i    (cause_num),
        .target_o (m_target)
    );

    trap_vector_calc #(.XLEN(XLEN)) svec_calc_i (
        .vec_i    (r_q.svec),
        .is_irq_i (is_irq),
        .num_i    (cause_num),
        .target_o (s_target)
    );

    always_comb begin
        r_d          = r_q;
        r_d.redirect = 1'b0;
        if (trap_valid_i) begin
            r_d.redirect = 1'b1;
            if (to_s) begin
                r_d.sepc    = trap_epc_i;
                r_d.scause  = trap_cause_i;
                r_d.sbad    = trap_bad_i;
                r_d.st.spie = r_q.st.sie;
                r_d.st.spp  = cur_priv_i[0];
                r_d.st.sie  = 1'b0;
                r_d.pc      = s_target;
                r_d.priv    = PRIV_S;
            end else begin
                r_d.mepc    = trap_epc_i;
                r_d.mcause  = trap_cause_i;
                if (trap_bad_valid_i) begin
                    r_d.mbad = trap_bad_i;
                end
                r_d.st.mpie = r_q.st.mie;
                r_d.st.mpp  = cur_priv_i;
                r_d.st.mie  = 1'b0;
                r_d.pc      = m_target;
                r_d.priv    = PRIV_M;
            end
        end else if (csr_we_i) begin
            case (csr_sel_i)
                SEL_MVEC:    r_d.mvec    = csr_wdata_i & VEC_WMASK;
                SEL_SVEC:    r_d.svec    = csr_wdata_i & VEC_WMASK;
                SEL_EXC_DLG: r_d.exc_dlg = csr_wdata_i;
                SEL_IRQ_DLG: r_d.irq_dlg = csr_wdata_i;
                SEL_STATUS: begin
                    r_d.st.sie  = csr_wdata_i[ST_SIE];
                    r_d.st.mie  = csr_wdata_i[ST_MIE];
                    r_d.st.spie = csr_wdata_i[ST_SPIE];
                    r_d.st.mpie = csr_wdata_i[ST_MPIE];
                    r_d.st.spp  = csr_wdata_i[ST_SPP];
                    r_d.st.mpp  = csr_wdata_i[ST_MPP_LO+1:ST_MPP_LO];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.priv <= PRIV_M;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        status_o                            = '0;
        status_o[ST_SIE]                    = r_q.st.sie;
        status_o[ST_MIE]                    = r_q.st.mie;
        status_o[ST_SPIE]                   = r_q.st.spie;
        status_o[ST_MPIE]                   = r_q.st.mpie;
        status_o[ST_SPP]                    = r_q.st.spp;
        status_o[ST_MPP_LO+1:ST_MPP_LO]     = r_q.st.mpp;
    end

    assign redirect_o  = r_q.redirect;
    assign next_pc_o   = r_q.pc;
    assign next_priv_o = r_q.priv;
    assign mvec_o      = r_q.mvec;
    assign svec_o      = r_q.svec;
    assign medeleg_o   = r_q.exc_dlg;
    assign mideleg_o   = r_q.irq_dlg;
    assign mepc_o      = r_q.mepc;
    assign mcause_o    = r_q.mcause;
    assign mbad_o      = r_q.mbad;
    assign sepc_o      = r_q.sepc;
    assign scause_o    = r_q.scause;
    assign sbad_o      = r_q.sbad;

    a_r2_machine_stays_machine: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && cur_priv_i == PRIV_M) |=> (next_priv_o == PRIV_M));

    a_r3_sup_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && to_s) |=> (next_priv_o == PRIV_S && !status_o[ST_SIE]
            && status_o[ST_SPIE] == $past(status_o[ST_SIE])
            && sepc_o == $past(trap_epc_i)));

    a_r4_mach_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !to_s) |=> (next_priv_o == PRIV_M && !status_o[ST_MIE]
            && status_o[ST_MPIE] == $past(status_o[ST_MIE])
            && mepc_o == $past(trap_epc_i)));

    a_r5_bad_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !to_s && !trap_bad_valid_i) |=> $stable(mbad_o));

    a_r7_vec_bit1_low: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && !trap_valid_i && csr_sel_i == SEL_MVEC) |=> !mvec_o[1]);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> !redirect_o);

    a_r10_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && csr_we_i) |=> ($stable(medeleg_o) && $stable(mvec_o)));
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid_i = 1'b0;
    logic [31:0] trap_cause_i = '0;
    logic [31:0] trap_epc_i = '0;
    logic [31:0] trap_bad_i = '0;
    logic        trap_bad_valid_i = 1'b0;
    logic [1:0]  cur_priv_i = 2'd3;
    logic        csr_we_i = 1'b0;
    logic [2:0]  csr_sel_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic        redirect_o;
    logic [31:0] next_pc_o;
    logic [1:0]  next_priv_o;
    logic [31:0] status_o, mvec_o, svec_o, medeleg_o, mideleg_o;
    logic [31:0] mepc_o, mcause_o, mbad_o, sepc_o, scause_o, sbad_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [31:0] e_mvec = 0, e_svec = 0, e_med = 0, e_mid = 0;
    logic [31:0] e_mepc = 0, e_mcause = 0, e_mbad = 0;
    logic [31:0] e_sepc = 0, e_scause = 0, e_sbad = 0;
    logic        e_sie = 0, e_mie = 0, e_spie = 0, e_mpie = 0, e_spp = 0;
    logic [1:0]  e_mpp = 0;

    always #10 clk = ~clk;

    trap_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid_i), .trap_cause_i(trap_cause_i),
        .trap_epc_i(trap_epc_i), .trap_bad_i(trap_bad_i), .trap_bad_valid_i(trap_bad_valid_i),
        .cur_priv_i(cur_priv_i), .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i),
        .csr_wdata_i(csr_wdata_i), .redirect_o(redirect_o), .next_pc_o(next_pc_o),
        .next_priv_o(next_priv_o), .status_o(status_o), .mvec_o(mvec_o), .svec_o(svec_o),
        .medeleg_o(medeleg_o), .mideleg_o(mideleg_o), .mepc_o(mepc_o), .mcause_o(mcause_o),
        .mbad_o(mbad_o), .sepc_o(sepc_o), .scause_o(scause_o), .sbad_o(sbad_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] e_status();
        logic [31:0] s = '0;
        s[1] = e_sie; s[3] = e_mie; s[5] = e_spie; s[7] = e_mpie; s[8] = e_spp;
        s[12:11] = e_mpp;
        return s;
    endfunction

    task automatic csr_wr(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        csr_we_i = 1'b1; csr_sel_i = sel; csr_wdata_i = val;
        @(negedge clk);
        csr_we_i = 1'b0;
        case (sel)
            3'd0: e_mvec = val & 32'hFFFF_FFFD;
            3'd1: e_svec = val & 32'hFFFF_FFFD;
            3'd2: e_med = val;
            3'd3: e_mid = val;
            3'd4: begin
                e_sie = val[1]; e_mie = val[3]; e_spie = val[5]; e_mpie = val[7];
                e_spp = val[8]; e_mpp = val[12:11];
            end
            default: ;
        endcase
    endtask

    // also drives a simultaneous CSR write when clash=1 (R10)
    task automatic do_trap(input logic [31:0] cause, input logic [31:0] epc,
                           input logic [31:0] bad, input logic bv, input logic [1:0] prv,
                           input logic clash);
        logic        irq;
        logic [31:0] num, dlg, vec, exp_pc;
        logic        tos;
        irq = cause[31];
        num = {1'b0, cause[30:0]};
        dlg = irq ? e_mid : e_med;
        tos = (prv <= 2'd1) && (num < 32) && dlg[num[4:0]];
        vec = tos ? e_svec : e_mvec;
        exp_pc = (vec[0] && irq) ? ((vec & 32'hFFFF_FFFE) + (num << 2)) : (vec & 32'hFFFF_FFFE);
        @(negedge clk);
        trap_valid_i = 1'b1; trap_cause_i = cause; trap_epc_i = epc;
        trap_bad_i = bad; trap_bad_valid_i = bv; cur_priv_i = prv;
        if (clash) begin
            csr_we_i = 1'b1; csr_sel_i = 3'd2; csr_wdata_i = ~e_med;
        end
        if (tos) begin
            e_sepc = epc; e_scause = cause; e_sbad = bad;
            e_spie = e_sie; e_spp = prv[0]; e_sie = 1'b0;
        end else begin
            e_mepc = epc; e_mcause = cause;
            if (bv) e_mbad = bad;
            e_mpie = e_mie; e_mpp = prv; e_mie = 1'b0;
        end
        @(negedge clk);
        trap_valid_i = 1'b0; csr_we_i = 1'b0;
        chk("R9 redirect", {31'd0, redirect_o}, 32'd1);
        chk("R2 next_priv", {30'd0, next_priv_o}, tos ? 32'd1 : 32'd3);
        chk("R6 next_pc", next_pc_o, exp_pc);
        chk("R3/R4 status", status_o, e_status());
        if (tos) begin
            chk("R3 sepc", sepc_o, e_sepc);
            chk("R3 scause", scause_o, e_scause);
            chk("R3 sbad", sbad_o, e_sbad);
        end else begin
            chk("R4 mepc", mepc_o, e_mepc);
            chk("R4 mcause", mcause_o, e_mcause);
            chk("R5 mbad", mbad_o, e_mbad);
        end
        if (clash) chk("R10 deleg unchanged", medeleg_o, e_med);
        @(negedge clk);
        chk("R9 pulse ends", {31'd0, redirect_o}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 reset redirect", {31'd0, redirect_o}, 32'd0);
        chk("R9 reset next_priv", {30'd0, next_priv_o}, 32'd3);
        chk("R9 reset next_pc", next_pc_o, 32'd0);
        chk("R9 reset status", status_o, 32'd0);
        chk("R9 reset mvec", mvec_o, 32'd0);

        // R7 vector writes clear bit 1; deleg writes unmodified
        csr_wr(3'd0, 32'hFFFF_FFFF);
        chk("R7 mvec mask", mvec_o, 32'hFFFF_FFFD);
        csr_wr(3'd1, 32'h1234_5677);
        chk("R7 svec mask", svec_o, 32'h1234_5675);
        csr_wr(3'd2, 32'hFFFF_FFFF);
        chk("R7 medeleg", medeleg_o, 32'hFFFF_FFFF);
        // R8 status write field positions
        csr_wr(3'd4, 32'hFFFF_FFFF);
        chk("R8 status all", status_o, 32'h0000_19AA);
        csr_wr(3'd4, 32'h0000_0000);
        chk("R8 status clear", status_o, 32'h0);

        for (int vm = 0; vm < 2; vm++) begin
            csr_wr(3'd0, 32'h8000_1000 | vm);
            csr_wr(3'd1, 32'h4000_2000 | vm);
            csr_wr(3'd2, 32'hA5C3_5A3C);
            csr_wr(3'd3, 32'h0F0F_0222);
            for (int p = 0; p < 3; p++) begin
                logic [1:0] prv;
                prv = (p == 2) ? 2'd3 : 2'(p);
                for (int ir = 0; ir < 2; ir++) begin
                    for (int n = 0; n < 35; n++) begin
                        logic [31:0] num;
                        logic [31:0] stv;
                        num = (n == 34) ? 32'h7FFF_FFFF : 32'(n);
                        stv = 32'(((n ^ p) & 1) << 1) | 32'((((n >> 1) ^ ir) & 1) << 3)
                            | 32'(((n >> 2) & 1) << 8) | 32'(((n + vm) & 3) << 11);
                        csr_wr(3'd4, stv);
                        chk("R8 status load", status_o, e_status());
                        // R1 interrupt flag in bit 31 selects deleg mask
                        do_trap({ir[0], num[30:0]}, 32'h1000_0000 + 32'(n * 4),
                                32'hBAD0_0000 | 32'(n), n[0], prv, (n % 7) == 3);
                    end
                end
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule